// File: doc/BRIEF.md
# Strided and Indexed Vector Memory Unit

This block is the load/store path between a set of parallel 32-bit vector lanes and one single-ported, line-wide data cache. A vector memory command carries a base byte address, a byte stride, one byte offset per lane for indexed mode, an element count (VL), and a load/store flag. Commands wait in a request FIFO. Store data arrives one lane-wide word vector per group through a separate write FIFO.

Each element gets a byte address. The unit then visits the cache once for every distinct line touched by the current group of up to `LANES` elements. On each visit it serves all remaining lanes that fall in that line. A read crossbar steers any word of the returned line to any lane. A write crossbar places lane data at word positions in the line and raises a matching per-word enable. Load results leave as one lane vector per group, with a mask of the lanes in use. A single done pulse closes every command.

The cache side is a request held until the cache raises `c_ready`. This allows a latency of any length. Read data is valid in the same cycle as `c_ready`.

Top module: `vmem_unit`

## Requirements
- R1: In strided mode, element i of a group has byte address `group_base + stride * i`, where `stride` is a two's-complement byte count. The two low address bits are ignored.
- R2: In indexed mode, element i of a group has byte address `group_base + index_i`. `index_i` is bits [32*i+31 : 32*i] of `cmd_index`, and the stride plays no part in the element offset.
- R3: A command with VL above `LANES` is served in groups of `LANES` elements, with the last group partial. The group base starts at `cmd_base` and grows by `stride * LANES` for each group, in both modes.
- R4: Each group makes exactly one cache access for each distinct line its active elements touch. `c_addr` is the byte address shifted right by 6 (a 64-byte line of 16 words), and the line of the lowest-numbered unserved lane is visited first.
- R5: For a load, each group produces one `ld_valid` pulse. Lane i of `ld_data` holds word `addr[5:2]` of the line containing its address. `ld_mask` marks the active lanes, and inactive lanes read as zero.
- R6: For a store, `c_wen` bit w is set only when an active lane served by that access targets word w, and it carries that lane's data. When several lanes target one word, the highest-numbered lane wins.
- R7: Lanes at or beyond the remaining element count are masked. They write nothing, cause no access, and `ld_mask` is always a run of ones starting at lane 0.
- R8: Every accepted command produces exactly one `done` pulse, in the same cycle as its last group's `ld_valid` for loads. A VL of 0 produces `done` with no cache access.
- R9: Up to 4 commands can be queued while the unit is busy, and they complete in the order accepted.
- R10: While `c_req` is high and `c_ready` is low, the next cycle keeps `c_req` high with the same `c_addr` and `c_we`.
- R11: After reset, `c_req`, `ld_valid` and `done` are low and `cmd_ready` and `wq_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command push strobe |
| cmd_ready | output | 1 | Request FIFO has room |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_indexed | input | 1 | 1 = indexed, 0 = strided |
| cmd_base | input | 32 | Base byte address |
| cmd_stride | input | 32 | Byte stride (two's complement) |
| cmd_vl | input | 8 | Element count |
| cmd_index | input | 128 | Per-lane byte offsets, lane i at [32*i+31:32*i] |
| wq_valid | input | 1 | Store data push strobe |
| wq_ready | output | 1 | Write FIFO has room |
| wq_data | input | 128 | Store data for one group, lane i at [32*i+31:32*i] |
| c_req | output | 1 | Cache access request |
| c_we | output | 1 | Access is a write |
| c_addr | output | 26 | Line address |
| c_wdata | output | 512 | Line write data |
| c_wen | output | 16 | Per-word write enables |
| c_ready | input | 1 | Cache completes the access this cycle |
| c_rdata | input | 512 | Line read data, valid with c_ready |
| ld_valid | output | 1 | Load group result valid |
| ld_mask | output | 4 | Active lanes of the group |
| ld_data | output | 128 | Load data, lane i at [32*i+31:32*i] |
| done | output | 1 | Command finished |

## Verification
The bench targets lanes that share a line and lanes that share a word. A unit that did not merge lanes would show too many cache accesses. A unit that resolved the conflict toward the lower lane would leave the wrong word in memory.

It also covers negative and zero strides, indexed groups that scatter over several lines, and VL values that leave a partial last group. A wrong group-base step or missing masking shows up as corrupted memory words, wrong lanes in `ld_data`, or a wrong `ld_mask`. VL of 0 and commands queued back to back probe for missing or extra done pulses and for reordering. A random wait on the cache ready handshake catches a request that drops or changes address before it is accepted.

// File: rtl/vmu_pkg.sv
package vmu_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_GRP  = 2'd1,
      ST_ACC  = 2'd2
   } vmu_state_e;

endpackage

// File: rtl/vmu_fifo.sv
module vmu_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   input  logic         pop,
   output logic         out_nempty,
   output logic [W-1:0] out_data
);
   localparam int PW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("vmu_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  store_m [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [PW:0]   cnt;
   logic          push;

   assign in_ready   = (cnt != (PW+1)'(DEPTH));
   assign out_nempty = (cnt != '0);
   assign push       = in_valid && in_ready;
   assign out_data   = store_m[rp];

   always_ff @(posedge clk) begin
      if (push) store_m[wp] <= in_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R9: the controller never pops an empty queue
   a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (cnt != '0));

endmodule

// File: rtl/vmu_agen.sv
module vmu_agen #(
   parameter int LANES = 4,
   parameter int AW    = 32,
   parameter int BB    = 2,
   parameter int OW    = 4
) (
   input  logic [AW-1:0]            base,
   input  logic [AW-1:0]            stride,
   input  logic                     indexed,
   input  logic [LANES*AW-1:0]      idx,
   output logic [LANES*(AW-BB-OW)-1:0] line_o,
   output logic [LANES*OW-1:0]      wpos_o
);
   localparam int LB  = BB + OW;
   localparam int LAW = AW - LB;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [AW-1:0] off, sum;
      logic          lo_bits_unused;
      // R1 / R2: stride multiple or per-lane offset
      assign off = indexed ? idx[i*AW +: AW] : stride * AW'(i);
      assign sum = base + off;
      assign line_o[i*LAW +: LAW] = sum[AW-1:LB];
      assign wpos_o[i*OW +: OW]   = sum[LB-1:BB];
      assign lo_bits_unused       = ^sum[BB-1:0];
   end

endmodule

// File: rtl/vmu_xbar.sv
module vmu_xbar #(
   parameter int LANES      = 4,
   parameter int DW         = 32,
   parameter int LINE_WORDS = 16,
   parameter int OW         = 4
) (
   input  logic [LANES*OW-1:0]      wpos,
   input  logic [LANES-1:0]         sel,
   input  logic [LINE_WORDS*DW-1:0] line_rd,
   input  logic [LANES*DW-1:0]      lane_wd,
   output logic [LANES*DW-1:0]      lane_rd,
   output logic [LINE_WORDS*DW-1:0] line_wd,
   output logic [LINE_WORDS-1:0]    line_wen
);
   // read side: any line word to any lane
   for (genvar i = 0; i < LANES; i++) begin : g_rd
      assign lane_rd[i*DW +: DW] = line_rd[wpos[i*OW +: OW]*DW +: DW];
   end

   // write side: later (higher) lanes override earlier ones on a shared word
   for (genvar w = 0; w < LINE_WORDS; w++) begin : g_wr
      always_comb begin
         line_wen[w]          = 1'b0;
         line_wd[w*DW +: DW]  = '0;
         for (int i = 0; i < LANES; i++) begin
            if (sel[i] && (wpos[i*OW +: OW] == OW'(w))) begin
               line_wen[w]         = 1'b1;
               line_wd[w*DW +: DW] = lane_wd[i*DW +: DW];
            end
         end
      end
   end

endmodule

// File: rtl/vmem_unit.sv
module vmem_unit
   import vmu_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int DW         = 32,
   parameter int AW         = 32,
   parameter int LINE_WORDS = 16,
   parameter int VL_W       = 8,
   parameter int CQ_DEPTH   = 4,
   parameter int WQ_DEPTH   = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_valid,
   output logic                         cmd_ready,
   input  logic                         cmd_store,
   input  logic                         cmd_indexed,
   input  logic [AW-1:0]                cmd_base,
   input  logic [AW-1:0]                cmd_stride,
   input  logic [VL_W-1:0]              cmd_vl,
   input  logic [LANES*AW-1:0]          cmd_index,
   input  logic                         wq_valid,
   output logic                         wq_ready,
   input  logic [LANES*DW-1:0]          wq_data,
   output logic                         c_req,
   output logic                         c_we,
   output logic [AW-$clog2(LINE_WORDS)-$clog2(DW/8)-1:0] c_addr,
   output logic [LINE_WORDS*DW-1:0]     c_wdata,
   output logic [LINE_WORDS-1:0]        c_wen,
   input  logic                         c_ready,
   input  logic [LINE_WORDS*DW-1:0]     c_rdata,
   output logic                         ld_valid,
   output logic [LANES-1:0]             ld_mask,
   output logic [LANES*DW-1:0]          ld_data,
   output logic                         done
);
   localparam int BB    = $clog2(DW/8);
   localparam int OW    = $clog2(LINE_WORDS);
   localparam int LB    = BB + OW;
   localparam int LAW   = AW - LB;
   localparam int LIW   = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int CMD_W = 2 + 2*AW + VL_W + LANES*AW;

   if (DW < 16 || (DW % 8) != 0 || ((DW/8) & (DW/8 - 1)) != 0) begin : g_bad_dw
      $error("vmem_unit: DW must be a power-of-two byte count of at least 2 bytes");
   end
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_line
      $error("vmem_unit: LINE_WORDS must be a power of two of at least 2");
   end
   if (LANES < 1 || LANES >= (1 << VL_W)) begin : g_bad_lanes
      $error("vmem_unit: LANES must be at least 1 and below 2**VL_W");
   end
   if (LB >= AW) begin : g_bad_aw
      $error("vmem_unit: AW too small for the line size");
   end

   // ---------------- queues ----------------
   logic             cq_nempty, cq_pop;
   logic [CMD_W-1:0] cq_dout;
   logic             wq_nempty, wq_pop;
   logic [LANES*DW-1:0] wq_dout;

   vmu_fifo #(.W(CMD_W), .DEPTH(CQ_DEPTH)) u_req_q (
      .clk(clk), .rst_n(rst_n),
      .in_valid(cmd_valid), .in_ready(cmd_ready),
      .in_data({cmd_store, cmd_indexed, cmd_base, cmd_stride, cmd_vl, cmd_index}),
      .pop(cq_pop), .out_nempty(cq_nempty), .out_data(cq_dout)
   );

   vmu_fifo #(.W(LANES*DW), .DEPTH(WQ_DEPTH)) u_wr_q (
      .clk(clk), .rst_n(rst_n),
      .in_valid(wq_valid), .in_ready(wq_ready), .in_data(wq_data),
      .pop(wq_pop), .out_nempty(wq_nempty), .out_data(wq_dout)
   );

   logic                q_store, q_indexed;
   logic [AW-1:0]       q_base, q_stride;
   logic [VL_W-1:0]     q_vl;
   logic [LANES*AW-1:0] q_index;

   assign q_store   = cq_dout[CMD_W-1];
   assign q_indexed = cq_dout[CMD_W-2];
   assign q_base    = cq_dout[CMD_W-3 -: AW];
   assign q_stride  = cq_dout[CMD_W-3-AW -: AW];
   assign q_vl      = cq_dout[LANES*AW+VL_W-1 -: VL_W];
   assign q_index   = cq_dout[LANES*AW-1:0];

   // ---------------- command state ----------------
   vmu_state_e          st;
   logic                store_q, indexed_q;
   logic [AW-1:0]       base_q, stride_q;
   logic [VL_W-1:0]     rem_q;
   logic [LANES*AW-1:0] idx_q;
   logic [LANES-1:0]    pend_q, act_q;
   logic [LANES*DW-1:0] buf_q;
   logic                ld_valid_q, done_q;

   // ---------------- address generation ----------------
   logic [LANES*LAW-1:0] lane_line;
   logic [LANES*OW-1:0]  lane_wpos;

   vmu_agen #(.LANES(LANES), .AW(AW), .BB(BB), .OW(OW)) u_agen (
      .base(base_q), .stride(stride_q), .indexed(indexed_q), .idx(idx_q),
      .line_o(lane_line), .wpos_o(lane_wpos)
   );

   // active lanes of the current group (R7)
   logic [LANES-1:0] act_mask;
   for (genvar i = 0; i < LANES; i++) begin : g_act
      assign act_mask[i] = (rem_q > VL_W'(i));
   end

   logic [VL_W-1:0] grp_cnt;
   assign grp_cnt = (rem_q >= VL_W'(LANES)) ? VL_W'(LANES) : rem_q;

   // lead lane: lowest-numbered unserved lane (R4)
   logic [LIW-1:0] lead;
   logic           lead_found;
   always_comb begin
      lead       = '0;
      lead_found = 1'b0;
      for (int i = 0; i < LANES; i++) begin
         if (pend_q[i] && !lead_found) begin
            lead       = LIW'(i);
            lead_found = 1'b1;
         end
      end
   end

   logic [LAW-1:0]   lead_line;
   logic [LANES-1:0] match;
   logic             last_acc;
   assign lead_line = lane_line[lead*LAW +: LAW];
   for (genvar i = 0; i < LANES; i++) begin : g_match
      assign match[i] = pend_q[i] && (lane_line[i*LAW +: LAW] == lead_line);
   end
   assign last_acc = ((pend_q & ~match) == '0);

   // ---------------- crossbars ----------------
   logic [LANES*DW-1:0]      lane_rd;
   logic [LINE_WORDS*DW-1:0] x_wd;
   logic [LINE_WORDS-1:0]    x_wen;

   vmu_xbar #(.LANES(LANES), .DW(DW), .LINE_WORDS(LINE_WORDS), .OW(OW)) u_xbar (
      .wpos(lane_wpos), .sel(match), .line_rd(c_rdata), .lane_wd(wq_dout),
      .lane_rd(lane_rd), .line_wd(x_wd), .line_wen(x_wen)
   );

   // ---------------- cache port ----------------
   assign c_req   = (st == ST_ACC);
   assign c_we    = store_q;
   assign c_addr  = lead_line;
   assign c_wdata = x_wd;
   assign c_wen   = store_q ? x_wen : '0;

   assign cq_pop  = (st == ST_IDLE) && cq_nempty;
   assign wq_pop  = (st == ST_ACC) && c_ready && last_acc && store_q;

   assign ld_valid = ld_valid_q;
   assign ld_mask  = act_q;
   assign ld_data  = buf_q;
   assign done     = done_q;

   // ---------------- control ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         store_q    <= 1'b0;
         indexed_q  <= 1'b0;
         base_q     <= '0;
         stride_q   <= '0;
         rem_q      <= '0;
         idx_q      <= '0;
         pend_q     <= '0;
         act_q      <= '0;
         buf_q      <= '0;
         ld_valid_q <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         ld_valid_q <= 1'b0;
         done_q     <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (cq_nempty) begin
                  store_q   <= q_store;
                  indexed_q <= q_indexed;
                  base_q    <= q_base;
                  stride_q  <= q_stride;
                  rem_q     <= q_vl;
                  idx_q     <= q_index;
                  if (q_vl == '0) done_q <= 1'b1;   // R8: empty command
                  else            st     <= ST_GRP;
               end
            end
            ST_GRP: begin
               if (!store_q || wq_nempty) begin
                  pend_q <= act_mask;
                  act_q  <= act_mask;
                  buf_q  <= '0;
                  st     <= ST_ACC;
               end
            end
            ST_ACC: begin
               if (c_ready) begin
                  pend_q <= pend_q & ~match;
                  for (int i = 0; i < LANES; i++) begin
                     if (match[i] && !store_q) buf_q[i*DW +: DW] <= lane_rd[i*DW +: DW];
                  end
                  if (last_acc) begin
                     ld_valid_q <= !store_q;
                     rem_q      <= rem_q - grp_cnt;
                     base_q     <= base_q + stride_q * AW'(LANES);   // R3
                     if (rem_q <= VL_W'(LANES)) begin
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                     end else begin
                        st     <= ST_GRP;
                     end
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // ---------------- assertions ----------------
   // R10: request holds until accepted
   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (c_req && !c_ready) |=> (c_req && $stable(c_addr) && $stable(c_we)));

   // R4: each access serves a non-empty subset of the unserved lanes
   a_r4_match_subset: assert property (@(posedge clk) disable iff (!rst_n)
      c_req |-> ((match != '0) && ((match & ~pend_q) == '0)));

   // R6: a write access always writes at least one word
   a_r6_wen_present: assert property (@(posedge clk) disable iff (!rst_n)
      (c_req && c_we) |-> (c_wen != '0));

   // R7: active lanes form a run starting at lane 0
   a_r7_mask_run: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> (ld_mask[0] && (((ld_mask + 1'b1) & ld_mask) == '0)));

   // R8: completion is reported only when no access is outstanding
   a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !c_req);

   // R5: a load result never coincides with a pending write
   a_r5_ld_not_store: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> !(c_req && c_we));

endmodule

// File: tb/vmem_unit_tb_top.sv
module vmem_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int L  = 4;
   localparam int LW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0, cmd_ready;
   logic          cmd_store = 1'b0, cmd_indexed = 1'b0;
   logic [31:0]   cmd_base = '0, cmd_stride = '0;
   logic [7:0]    cmd_vl = '0;
   logic [127:0]  cmd_index = '0;
   logic          wq_valid = 1'b0, wq_ready;
   logic [127:0]  wq_data = '0;
   logic          c_req, c_we;
   logic [25:0]   c_addr;
   logic [511:0]  c_wdata;
   logic [15:0]   c_wen;
   logic          c_ready = 1'b0;
   logic [511:0]  c_rdata = '0;
   logic          ld_valid;
   logic [3:0]    ld_mask;
   logic [127:0]  ld_data;
   logic          done;

   always #(CLK_PERIOD/2) clk = ~clk;

   vmem_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_store(cmd_store),
      .cmd_indexed(cmd_indexed), .cmd_base(cmd_base), .cmd_stride(cmd_stride),
      .cmd_vl(cmd_vl), .cmd_index(cmd_index),
      .wq_valid(wq_valid), .wq_ready(wq_ready), .wq_data(wq_data),
      .c_req(c_req), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
      .c_wen(c_wen), .c_ready(c_ready), .c_rdata(c_rdata),
      .ld_valid(ld_valid), .ld_mask(ld_mask), .ld_data(ld_data), .done(done)
   );

   logic [31:0] mem_dut [256];
   logic [31:0] ref_mem [256];
   logic [127:0] exp_data_q [$];
   logic [3:0]   exp_mask_q [$];
   int n_chk = 0, n_fail = 0;
   int acc_cnt = 0, exp_acc = 0;
   int done_cnt = 0, issued = 0;

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   // cache model: random wait, line read/write on acceptance
   initial begin
      int wait_left = 0;
      forever begin
         @(negedge clk);
         if (c_req) begin
            if (wait_left == 0) begin
               for (int w = 0; w < LW; w++) begin
                  c_rdata[w*32 +: 32] = mem_dut[{c_addr[3:0], 4'(w)}];
                  if (c_we && c_wen[w]) mem_dut[{c_addr[3:0], 4'(w)}] = c_wdata[w*32 +: 32];
               end
               c_ready = 1'b1;
               acc_cnt++;
               wait_left = $urandom % 3;
            end else begin
               c_ready = 1'b0;
               wait_left--;
            end
         end else begin
            c_ready = 1'b0;
         end
      end
   end

   // output monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && ld_valid) begin
            if (exp_data_q.size() == 0) begin
               chk(1'b0, "R5 unexpected ld_valid", {124'd0, ld_mask}, 128'd0);
            end else begin
               logic [127:0] ed;
               logic [3:0]   em;
               ed = exp_data_q.pop_front();
               em = exp_mask_q.pop_front();
               chk(ld_mask == em, "R7 ld_mask", {124'd0, ld_mask}, {124'd0, em});
               chk(ld_data == ed, "R5 R1 R2 R3 ld_data", ld_data, ed);
            end
         end
         if (rst_n && done) done_cnt++;
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   task automatic issue(input bit st, input bit ix, input logic [31:0] base,
                        input logic [31:0] stride, input int vl, input logic [127:0] idx);
      int groups;
      logic [127:0] wd [4];
      groups = (vl + L - 1) / L;
      for (int g = 0; g < groups; g++) begin
         logic [31:0] gb;
         logic [31:0] a [L];
         logic [127:0] ed;
         logic [3:0] em;
         ed = '0; em = '0;
         gb = base + stride * 32'(L * g);
         for (int i = 0; i < L; i++) begin
            a[i] = gb + (ix ? idx[i*32 +: 32] : stride * 32'(i));
            wd[g][i*32 +: 32] = $urandom;
         end
         for (int i = 0; i < L; i++) begin
            if (i < vl - L*g) begin
               bit fresh = 1'b1;
               for (int j = 0; j < i; j++) if ((a[j] >> 6) == (a[i] >> 6)) fresh = 1'b0;
               if (fresh) exp_acc++;
               if (st) ref_mem[a[i][9:2]] = wd[g][i*32 +: 32];
               else begin
                  ed[i*32 +: 32] = ref_mem[a[i][9:2]];
                  em[i] = 1'b1;
               end
            end
         end
         if (!st) begin
            exp_data_q.push_back(ed);
            exp_mask_q.push_back(em);
         end
      end
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_store = st; cmd_indexed = ix; cmd_base = base; cmd_stride = stride;
      cmd_vl = 8'(vl); cmd_index = idx; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      issued++;
      if (st) begin
         for (int g = 0; g < groups; g++) begin
            while (!wq_ready) @(negedge clk);
            wq_data = wd[g]; wq_valid = 1'b1;
            @(negedge clk);
            wq_valid = 1'b0;
         end
      end
   endtask

   task automatic wait_all(input string tag);
      int t = 0;
      while (done_cnt < issued && t < 4000) begin
         @(negedge clk); #1;
         t++;
      end
      repeat (3) @(negedge clk);
      #1;
      chk(done_cnt == issued, {tag, " R8 R9 done count"}, 128'(done_cnt), 128'(issued));
      chk(acc_cnt == exp_acc, {tag, " R4 R7 access count"}, 128'(acc_cnt), 128'(exp_acc));
      chk(exp_data_q.size() == 0, {tag, " R5 missing load groups"}, 128'(exp_data_q.size()), 128'd0);
      begin
         int bad = 0;
         int first = -1;
         for (int k = 0; k < 256; k++) if (mem_dut[k] !== ref_mem[k]) begin
            bad++;
            if (first < 0) first = k;
         end
         chk(bad == 0, {tag, " R6 R7 memory image"}, 128'(bad), 128'(first));
      end
   endtask

   function automatic logic [127:0] mk_idx(input int o0, input int o1, input int o2, input int o3);
      return {32'(o3), 32'(o2), 32'(o1), 32'(o0)};
   endfunction

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int k = 0; k < 256; k++) begin
         mem_dut[k] = $urandom;
         ref_mem[k] = mem_dut[k];
      end
      repeat (4) @(negedge clk);
      chk(c_req == 1'b0, "R11 c_req in reset", 128'(c_req), 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(c_req == 1'b0 && done == 1'b0 && ld_valid == 1'b0, "R11 outputs idle",
          {125'd0, c_req, done, ld_valid}, 128'd0);
      chk(cmd_ready && wq_ready, "R11 queues ready", {126'd0, cmd_ready, wq_ready}, 128'd3);

      // R1 R4: unit stride, one line
      issue(0, 0, 32'h40, 32'd4, 4, '0);               wait_all("unit-stride load");
      // R6 R7: partial store leaves lane 3 word untouched
      issue(1, 0, 32'h80, 32'd4, 3, '0);               wait_all("partial store");
      // R4: line stride gives one access per lane
      issue(0, 0, 32'h100, 32'd64, 4, '0);             wait_all("line-stride load");
      // R2 R6: indexed store, lanes 0/2 and 1/3 collide, higher wins
      issue(1, 1, 32'h200, 32'd0, 4, mk_idx(0, 8, 0, 8)); wait_all("indexed conflict store");
      // R2: indexed load across lines, stride ignored
      issue(0, 1, 32'h0, 32'd12, 4, mk_idx(300, 4, 64, 128)); wait_all("indexed load");
      // R8: empty command
      issue(0, 0, 32'h40, 32'd4, 0, '0);               wait_all("vl zero");
      // R3: three groups, partial tail, negative stride
      issue(0, 0, 32'h300, -32'sd8, 10, '0);           wait_all("multi-group load");
      issue(1, 1, 32'h20, 32'd16, 9, mk_idx(0, 4, 100, 4)); wait_all("multi-group indexed store");
      // R9: back-to-back queued commands keep order
      issue(1, 0, 32'h140, 32'd4, 8, '0);
      issue(0, 0, 32'h140, 32'd4, 8, '0);
      issue(0, 0, 32'h0, 32'd0, 0, '0);
      wait_all("queued commands");

      for (int n = 0; n < 70; n++) begin
         bit st, ix;
         int vl;
         logic [31:0] base, stride;
         logic [127:0] idx;
         st = 1'($urandom);
         ix = 1'($urandom);
         vl = $urandom % 17;
         base = ($urandom % 256) << 2;
         if ($urandom % 4 == 0) stride = ($urandom % 64) << 2;
         else stride = 32'(int'($urandom % 9) - 4) << 2;
         for (int i = 0; i < L; i++)
            idx[i*32 +: 32] = ($urandom % 2) ? (($urandom % 16) << 2) : (($urandom % 256) << 2);
         issue(st, ix, base, stride, vl, idx);
         if (n % 5 == 4) wait_all("random batch");
      end
      wait_all("random tail");
      summary();
   end

endmodule